// File: doc/BRIEF.md
# Trap Exception Capture Unit

This unit sits next to a pipelined integer core and takes the two instruction-triggered traps: the system call and the breakpoint. When the pipeline reports that one of these instructions has reached the exception point, the unit acts in that same cycle. It tells fetch to jump to the shared exception entry point and tells the pipeline to discard every younger instruction. On the next clock edge it records three things: where the trap came from, which kind of trap it was, and whether the trap sat in a branch delay slot.

The recorded return address needs care. A trap in a delay slot records the address of the branch in front of it, and a status flag marks that case. The unit also latches the 20-bit field that the trap instruction leaves unused, so that a handler can tell variants of the same trap apart.

The pipeline can also signal a return from the handler. The unit then redirects fetch to the stored return address exactly as stored, with no increment, and clears the exception-level flag.

Top module: `trap_capture`

## Requirements
- R1: When a trap is taken (`trap_sys` or `trap_brk` high while `older_exc` is low), `redirect_valid` and `flush_younger` are high in that same cycle and `redirect_pc` equals `VEC_BASE + VEC_OFFSET` (default 0x80000180). This holds whatever the value of `status_exl`.
- R2: On the clock edge of a taken trap, `cause_reg[6:2]` is loaded with 8 for a system call or 9 for a breakpoint. All other bits of `cause_reg` stay 0.
- R3: A taken trap with `in_delay_slot` low loads `epc` with `insn_addr`.
- R4: A taken trap with `in_delay_slot` high loads `epc` with `insn_addr - 4`.
- R5: Every taken trap loads `status_bd` with the value of `in_delay_slot`.
- R6: Every taken trap loads `trap_code` with `insn_word[25:6]`.
- R7: Every taken trap sets `status_exl` to 1, including when it is already 1 (a nested trap).
- R8: While `older_exc` is high, no trap is taken. `epc`, `cause_reg`, `status_bd` and `trap_code` keep their values, and the unit raises no redirect for the trap.
- R9: If `trap_sys` and `trap_brk` are both high, exactly one capture occurs and the system-call code 8 is recorded.
- R10: `eret` with no trap taken in that cycle drives `redirect_valid` and `flush_younger` high and sets `redirect_pc` equal to the current `epc`, not incremented. `status_exl` is cleared on the next edge. A trap taken in the same cycle overrides the return.
- R11: After reset, `epc`, `cause_reg`, `trap_code`, `status_bd` and `status_exl` are 0, and with no request pending `redirect_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_sys | input | 1 | System-call instruction at the exception point |
| trap_brk | input | 1 | Breakpoint instruction at the exception point |
| older_exc | input | 1 | An older instruction is raising its own exception |
| in_delay_slot | input | 1 | The trap instruction sits in a branch delay slot |
| insn_addr | input | ADDR_W | Address of the trap instruction |
| insn_word | input | 32 | Encoding of the trap instruction |
| eret | input | 1 | Return from exception |
| epc | output | ADDR_W | Exception return address |
| cause_reg | output | 32 | Cause register, exception code in bits 6:2 |
| status_bd | output | 1 | Last trap was in a delay slot |
| status_exl | output | 1 | Exception level active |
| trap_code | output | 20 | Captured bits 25:6 of the trap instruction |
| redirect_valid | output | 1 | Fetch must be redirected this cycle |
| redirect_pc | output | ADDR_W | Fetch redirect target |
| flush_younger | output | 1 | Discard all younger instructions this cycle |

## Verification
The capture path is driven from a vector table. The table mixes both trap kinds with the delay-slot flag set and clear, so the code value, the rewind of the return address and the delay flag are each tested on their own. One vector rewinds across a power-of-two boundary and another rewinds to address zero, which exposes subtraction and carry errors. Trap words with a field of all zeros, all ones and mixed values show whether the right bit slice is latched. Directed cases then cover:
- simultaneous requests, which tell priority apart from a merged code;
- a blocked trap behind an older exception, which shows that the stored state is left alone;
- return alone and return together with a trap, which separate the no-increment target from trap precedence.

// File: rtl/trap_capture.sv
module trap_capture #(
  parameter int          ADDR_W     = 32,
  parameter logic [31:0] VEC_BASE   = 32'h8000_0000,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0180,
  parameter logic [4:0]  CODE_SYS   = 5'd8,
  parameter logic [4:0]  CODE_BRK   = 5'd9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_sys,
  input  logic              trap_brk,
  input  logic              older_exc,
  input  logic              in_delay_slot,
  input  logic [ADDR_W-1:0] insn_addr,
  input  logic [31:0]       insn_word,
  input  logic              eret,
  output logic [ADDR_W-1:0] epc,
  output logic [31:0]       cause_reg,
  output logic              status_bd,
  output logic              status_exl,
  output logic [19:0]       trap_code,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              flush_younger
);

  localparam logic [ADDR_W-1:0] VECTOR = ADDR_W'(VEC_BASE + VEC_OFFSET);
  localparam logic [ADDR_W-1:0] SLOT   = ADDR_W'(4);

  logic       take;
  logic       leave;
  logic [4:0] code_q;

  assign take  = (trap_sys | trap_brk) & ~older_exc;
  assign leave = eret & ~take;

  assign redirect_valid = take | leave;
  assign flush_younger  = redirect_valid;
  assign redirect_pc    = take ? VECTOR : epc;
  assign cause_reg      = {25'b0, code_q, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc        <= '0;
      code_q     <= '0;
      status_bd  <= 1'b0;
      status_exl <= 1'b0;
      trap_code  <= '0;
    end else if (take) begin
      epc        <= in_delay_slot ? insn_addr - SLOT : insn_addr;
      code_q     <= trap_sys ? CODE_SYS : CODE_BRK;
      status_bd  <= in_delay_slot;
      status_exl <= 1'b1;
      trap_code  <= insn_word[25:6];
    end else if (leave) begin
      status_exl <= 1'b0;
    end
  end

  assert_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((trap_sys || trap_brk) && !older_exc) |-> (flush_younger && redirect_pc == VECTOR));

  assert_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cause_reg[6:2] == CODE_SYS || cause_reg[6:2] == CODE_BRK));

  assert_epc_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_delay_slot) |=> epc == $past(insn_addr));

  assert_epc_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_delay_slot) |=> epc == $past(insn_addr) - SLOT);

  assert_bd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> status_bd == $past(in_delay_slot));

  assert_exl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> status_exl);

  assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    older_exc |=> ($stable(epc) && $stable(cause_reg) && $stable(trap_code)));

  assert_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !trap_sys && !trap_brk) |=> !status_exl);

endmodule

// File: tb/test_trap_capture.sv
module test_trap_capture;
  localparam int CLK_P = 10;
  localparam logic [31:0] VEC = 32'h8000_0180;
  localparam int NV = 7;

  // vector columns: sys, brk, slot, addr, word, expected epc, expected code, expected field
  localparam logic        T_SYS [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic        T_BRK [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic        T_DS  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] T_ADR [NV] = '{32'h0040_0010, 32'h0040_0104, 32'h1000_0000,
                                         32'hBFC0_0000, 32'h0000_0200, 32'h0000_0004, 32'h0000_1238};
  localparam logic [31:0] T_WRD [NV] = '{32'h02AF_378C, 32'h0048_D14D, 32'h0000_000C,
                                         32'h03FF_FFCD, 32'h0000_0040, 32'hFC00_003D, 32'h0155_554C};
  localparam logic [31:0] T_EPC [NV] = '{32'h0040_0010, 32'h0040_0100, 32'h0FFF_FFFC,
                                         32'hBFC0_0000, 32'h0000_0200, 32'h0000_0000, 32'h0000_1238};
  localparam logic [4:0]  T_CC  [NV] = '{5'd8, 5'd9, 5'd8, 5'd9, 5'd8, 5'd9, 5'd8};
  localparam logic [19:0] T_TC  [NV] = '{20'hABCDE, 20'h12345, 20'h00000,
                                         20'hFFFFF, 20'h00001, 20'h00000, 20'h55555};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_sys = 0, trap_brk = 0, older_exc = 0, in_delay_slot = 0, eret = 0;
  logic [31:0] insn_addr = '0, insn_word = '0;
  logic [31:0] epc, cause_reg, redirect_pc;
  logic [19:0] trap_code;
  logic status_bd, status_exl, redirect_valid, flush_younger;
  int checks = 0, fails = 0;
  logic [31:0] saved_epc, saved_cause;

  always #(CLK_P/2) clk = ~clk;

  trap_capture i_trap_capture (
    .clk(clk), .rst_n(rst_n), .trap_sys(trap_sys), .trap_brk(trap_brk),
    .older_exc(older_exc), .in_delay_slot(in_delay_slot), .insn_addr(insn_addr),
    .insn_word(insn_word), .eret(eret), .epc(epc), .cause_reg(cause_reg),
    .status_bd(status_bd), .status_exl(status_exl), .trap_code(trap_code),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .flush_younger(flush_younger)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    trap_sys = 0; trap_brk = 0; older_exc = 0; eret = 0; in_delay_slot = 0;
  endtask

  initial begin
    #(CLK_P*100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 epc", epc, 0);
    chk("R11 cause", cause_reg, 0);
    chk("R11 code", {12'b0, trap_code}, 0);
    chk("R11 bd/exl", {30'b0, status_bd, status_exl}, 0);
    chk("R11 redirect", {31'b0, redirect_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      trap_sys = T_SYS[i]; trap_brk = T_BRK[i]; in_delay_slot = T_DS[i];
      insn_addr = T_ADR[i]; insn_word = T_WRD[i];
      #1;
      // R1 same-cycle redirect, also while exl already set (nested, R7)
      chk("R1 redirect_valid", {31'b0, redirect_valid}, 1);
      chk("R1 flush", {31'b0, flush_younger}, 1);
      chk("R1 redirect_pc", redirect_pc, VEC);
      @(posedge clk); #1;
      chk("R2/R9 cause", cause_reg, {25'b0, T_CC[i], 2'b00});
      chk(T_DS[i] ? "R4 epc" : "R3 epc", epc, T_EPC[i]);
      chk("R5 bd", {31'b0, status_bd}, {31'b0, T_DS[i]});
      chk("R6 code", {12'b0, trap_code}, {12'b0, T_TC[i]});
      chk("R7 exl", {31'b0, status_exl}, 1);
      idle();
    end

    // R8 older exception blocks the trap
    saved_epc = epc; saved_cause = cause_reg;
    @(negedge clk);
    trap_brk = 1; older_exc = 1; in_delay_slot = 1;
    insn_addr = 32'h0000_7770; insn_word = 32'h03FF_FFCD;
    #1;
    chk("R8 redirect", {31'b0, redirect_valid}, 0);
    chk("R8 flush", {31'b0, flush_younger}, 0);
    @(posedge clk); #1;
    chk("R8 epc", epc, saved_epc);
    chk("R8 cause", cause_reg, saved_cause);
    chk("R8 code", {12'b0, trap_code}, 32'h55555);
    chk("R8 bd", {31'b0, status_bd}, 0);
    idle();

    // R10 return: target is epc without increment, exl clears
    @(negedge clk);
    eret = 1;
    #1;
    chk("R10 redirect_valid", {31'b0, redirect_valid}, 1);
    chk("R10 redirect_pc", redirect_pc, 32'h0000_1238);
    @(posedge clk); #1;
    chk("R10 exl clear", {31'b0, status_exl}, 0);
    chk("R10 epc kept", epc, 32'h0000_1238);
    idle();

    // R10 trap and return in the same cycle: trap wins
    @(negedge clk);
    eret = 1; trap_brk = 1; in_delay_slot = 1;
    insn_addr = 32'h0000_0A00; insn_word = 32'h0000_0000;
    #1;
    chk("R10 trap precedence pc", redirect_pc, VEC);
    @(posedge clk); #1;
    chk("R10 trap precedence exl", {31'b0, status_exl}, 1);
    chk("R4 epc rewind", epc, 32'h0000_09FC);
    chk("R2 brk code", cause_reg, 32'd9 << 2);
    idle();

    // idle cycle: nothing moves, no redirect
    @(negedge clk); #1;
    chk("R1 idle no redirect", {31'b0, redirect_valid}, 0);
    @(posedge clk); #1;
    chk("R3 idle epc stable", epc, 32'h0000_09FC);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule